// File: doc/BRIEF.md
# Configuration Key-Lock Port

This block is a pair of byte-wide host I/O registers: an index port and a data port at the next address. The host writes a register number to the index port, then reads or writes the selected register through the data port. Right after reset the port is sealed. It opens only when a fixed four-byte key has been written, back to back, to the index port. The last key byte depends on which of two base addresses the block is strapped to. A single write to a dedicated exit register seals the port again.

Once open, the port gives access to a small register set. Some registers are global: a logical-device selector, a read-only two-byte chip identifier, and a flash-segment control register whose bits drive output pins. Two more registers are reached only while the flash logical device is selected. They hold the two bytes of the flash controller's I/O base, which also drives an output bus. The host bus cycle itself and the devices that use these outputs sit outside the block. The host makes at most one access per clock, as a one-cycle strobe.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the port is sealed (`cfg_open`=0), `io_rdata` is 0xFF, the control outputs take the reset value `SEG_RST` (all zero by default), and `flash_base` equals `FB_RST` (0x0290 by default).
- R2: The port opens after four consecutive index-port writes of 0x87, 0x01, 0x55 and a final byte. The final byte is 0x55 when `alt_base`=0 and 0xAA when `alt_base`=1. `cfg_open` rises in the cycle after the clock edge that takes the final byte, and the third byte alone does not open the port.
- R3: While the key is being matched, any index write that does not match the expected byte restarts the match. If that byte is 0x87, it is taken as the first key byte. Data-port accesses do not disturb the match.
- R4: While the port is sealed, data-port reads return 0xFF and data-port writes change no register and no output.
- R5: A data-port read strobe loads `io_rdata` at the next clock edge, using the register selected before that edge. `io_rdata` then holds until the next data-port read. Index-port reads leave it unchanged.
- R6: Index 0x20 reads the high byte and index 0x21 reads the low byte of `CHIP_ID` (0x8716 by default). Writes to these two indices are ignored.
- R7: Index 0x24 holds six writable bits, and bits 7:6 read as 0. Bit 0 drives `flash_suspend`, bits 3:1 drive `seg_enable[2:0]`, bit 4 drives `flash_wr_en` and bit 5 drives `flash_pin_sel`.
- R8: Index 0x07 is a fully readable and writable 8-bit logical-device selector that resets to 0. Indices 0x64 and 0x65 hold the high and low bytes of `flash_base` only while the selector equals `FLASH_LDN` (7). With any other selector value they read as 0 and ignore writes.
- R9: A data write of 0x02 while index 0x02 is selected seals the port from the next cycle. Any other value written to index 0x02 has no effect. After sealing, the key must be matched again from its first byte.
- R10: Any index not listed above reads as 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_sel_data | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wdata | input | 8 | Write byte |
| alt_base | input | 1 | Base-address strap: 0 for the primary base, 1 for the alternate base |
| io_rdata | output | 8 | Registered read byte |
| cfg_open | output | 1 | High while configuration access is open |
| flash_suspend | output | 1 | Control bit 0 |
| seg_enable | output | 3 | Flash address segment enables, control bits 3:1 |
| flash_wr_en | output | 1 | Host write enable for the flash, control bit 4 |
| flash_pin_sel | output | 1 | Serial-flash pin select, control bit 5 |
| flash_base | output | 16 | Flash controller I/O base |

## Verification
A key matcher stuck one step ahead or behind shows up as `cfg_open` rising one write early or late, or never. The bench compares `cfg_open` on every cycle, so such a fault appears within one clock of the offending index write. A stale index or logical-device selector appears in `io_rdata` one cycle after the next data read. A lost register write appears at once on the control outputs or on `flash_base`. Because the reference model runs in lock-step with the design, any of these faults is reported in the cycle it first becomes visible, not at the end of a sequence.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int DW    = 8;
    localparam int SEG_W = 6;

    localparam logic [DW-1:0] KEY_B0     = 8'h87;
    localparam logic [DW-1:0] KEY_B1     = 8'h01;
    localparam logic [DW-1:0] KEY_B2     = 8'h55;
    localparam logic [DW-1:0] KEY_FIN_LO = 8'h55;
    localparam logic [DW-1:0] KEY_FIN_HI = 8'hAA;

    localparam logic [DW-1:0] IDX_EXIT  = 8'h02;
    localparam logic [DW-1:0] EXIT_VAL  = 8'h02;
    localparam logic [DW-1:0] IDX_LDN   = 8'h07;
    localparam logic [DW-1:0] IDX_ID_HI = 8'h20;
    localparam logic [DW-1:0] IDX_ID_LO = 8'h21;
    localparam logic [DW-1:0] IDX_SEG   = 8'h24;
    localparam logic [DW-1:0] IDX_FB_HI = 8'h64;
    localparam logic [DW-1:0] IDX_FB_LO = 8'h65;

    typedef enum logic [1:0] {
        KM_IDLE,
        KM_SAW_B0,
        KM_SAW_B1,
        KM_SAW_B2
    } km_state_e;

    typedef enum logic {
        LK_SEALED,
        LK_OPEN
    } lk_state_e;
endpackage

// File: rtl/cfgp_key_match.sv
module cfgp_key_match
    import cfgp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sealed,
    input  logic          wr_idx,
    input  logic [DW-1:0] wbyte,
    input  logic          alt_base,
    output logic          key_hit
);
    km_state_e state_q, state_d;
    logic [DW-1:0] fin_byte;
    km_state_e restart;

    assign fin_byte = alt_base ? KEY_FIN_HI : KEY_FIN_LO;
    assign restart  = (wbyte == KEY_B0) ? KM_SAW_B0 : KM_IDLE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!sealed) begin
            state_d = KM_IDLE;
        end else if (wr_idx) begin
            unique case (state_q)
                KM_IDLE:   state_d = restart;
                KM_SAW_B0: state_d = (wbyte == KEY_B1) ? KM_SAW_B1 : restart;
                KM_SAW_B1: state_d = (wbyte == KEY_B2) ? KM_SAW_B2 : restart;
                KM_SAW_B2: state_d = (wbyte == fin_byte) ? KM_IDLE : restart;
            endcase
        end
    end

    always_comb begin
        key_hit = sealed && wr_idx && (state_q == KM_SAW_B2) && (wbyte == fin_byte);
    end
endmodule

// File: rtl/cfgp_lock_ctl.sv
module cfgp_lock_ctl
    import cfgp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_hit,
    input  logic          wr_dat,
    input  logic [DW-1:0] idx,
    input  logic [DW-1:0] wbyte,
    output logic          open
);
    lk_state_e state_q, state_d;
    logic exit_req;

    assign exit_req = wr_dat && (idx == IDX_EXIT) && (wbyte == EXIT_VAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_SEALED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SEALED: if (key_hit)  state_d = LK_OPEN;
            LK_OPEN:   if (exit_req) state_d = LK_SEALED;
        endcase
    end

    always_comb begin
        open = (state_q == LK_OPEN);
    end
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
#(
    parameter logic [15:0]      CHIP_ID   = 16'h8716,
    parameter logic [DW-1:0]    FLASH_LDN = 8'h07,
    parameter logic [SEG_W-1:0] SEG_RST   = '0,
    parameter logic [15:0]      FB_RST    = 16'h0290
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open,
    input  logic             wr_idx,
    input  logic             wr_dat,
    input  logic             rd_dat,
    input  logic [DW-1:0]    wbyte,
    output logic [DW-1:0]    rdata,
    output logic [DW-1:0]    idx,
    output logic [SEG_W-1:0] seg,
    output logic [15:0]      fbase
);
    localparam int SEG_PAD = DW - SEG_W;

    logic [DW-1:0] idx_q, ldn_q, rdata_q, rd_val;
    logic [SEG_W-1:0] seg_q;
    logic [15:0] fb_q;
    logic flash_sel, dat_we;

    assign flash_sel = (ldn_q == FLASH_LDN);
    assign dat_we    = open && wr_dat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else if (open && wr_idx) idx_q <= wbyte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ldn_q <= '0;
            seg_q <= SEG_RST;
            fb_q  <= FB_RST;
        end else if (dat_we) begin
            case (idx_q)
                IDX_LDN: ldn_q <= wbyte;
                IDX_SEG: seg_q <= wbyte[SEG_W-1:0];
                IDX_FB_HI: if (flash_sel) fb_q[15:8] <= wbyte;
                IDX_FB_LO: if (flash_sel) fb_q[7:0]  <= wbyte;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (idx_q)
            IDX_LDN:   rd_val = ldn_q;
            IDX_ID_HI: rd_val = CHIP_ID[15:8];
            IDX_ID_LO: rd_val = CHIP_ID[7:0];
            IDX_SEG:   rd_val = {{SEG_PAD{1'b0}}, seg_q};
            IDX_FB_HI: rd_val = flash_sel ? fb_q[15:8] : '0;
            IDX_FB_LO: rd_val = flash_sel ? fb_q[7:0]  : '0;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '1;
        else if (rd_dat) rdata_q <= open ? rd_val : '1;
    end

    assign rdata = rdata_q;
    assign idx   = idx_q;
    assign seg   = seg_q;
    assign fbase = fb_q;
endmodule

// File: rtl/cfg_key_port.sv
module cfg_key_port
    import cfgp_pkg::*;
#(
    parameter logic [15:0]      CHIP_ID   = 16'h8716,
    parameter logic [DW-1:0]    FLASH_LDN = 8'h07,
    parameter logic [SEG_W-1:0] SEG_RST   = '0,
    parameter logic [15:0]      FB_RST    = 16'h0290
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic          io_sel_data,
    input  logic [7:0]    io_wdata,
    input  logic          alt_base,
    output logic [7:0]    io_rdata,
    output logic          cfg_open,
    output logic          flash_suspend,
    output logic [2:0]    seg_enable,
    output logic          flash_wr_en,
    output logic          flash_pin_sel,
    output logic [15:0]   flash_base
);
    logic wr_idx, wr_dat, rd_dat, key_hit;
    logic [DW-1:0] idx_cur;
    logic [SEG_W-1:0] seg_bits;

    assign wr_idx = io_wr && !io_sel_data;
    assign wr_dat = io_wr &&  io_sel_data;
    assign rd_dat = io_rd &&  io_sel_data;

    cfgp_key_match u_km (
        .clk(clk), .rst_n(rst_n), .sealed(!cfg_open), .wr_idx(wr_idx),
        .wbyte(io_wdata), .alt_base(alt_base), .key_hit(key_hit)
    );

    cfgp_lock_ctl u_lk (
        .clk(clk), .rst_n(rst_n), .key_hit(key_hit), .wr_dat(wr_dat),
        .idx(idx_cur), .wbyte(io_wdata), .open(cfg_open)
    );

    cfgp_regfile #(
        .CHIP_ID(CHIP_ID), .FLASH_LDN(FLASH_LDN), .SEG_RST(SEG_RST), .FB_RST(FB_RST)
    ) u_rf (
        .clk(clk), .rst_n(rst_n), .open(cfg_open), .wr_idx(wr_idx),
        .wr_dat(wr_dat), .rd_dat(rd_dat), .wbyte(io_wdata), .rdata(io_rdata),
        .idx(idx_cur), .seg(seg_bits), .fbase(flash_base)
    );

    assign flash_suspend = seg_bits[0];
    assign seg_enable    = seg_bits[3:1];
    assign flash_wr_en   = seg_bits[4];
    assign flash_pin_sel = seg_bits[5];
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
    import cfgp_pkg::*;
#(
    parameter logic [15:0] CHIP_ID = 16'h8716
) (
    input logic        clk,
    input logic        rst_n,
    input logic        io_wr,
    input logic        io_rd,
    input logic        io_sel_data,
    input logic [7:0]  io_wdata,
    input logic        alt_base,
    input logic [7:0]  io_rdata,
    input logic        cfg_open,
    input logic [7:0]  idx_cur,
    input logic [5:0]  ctl_bits,
    input logic [15:0] flash_base
);
    AST_SEALED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd && io_sel_data) |=> (io_rdata == 8'hFF)); // R4

    AST_SEALED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_wr && io_sel_data) |=> ($stable(flash_base) && $stable(ctl_bits))); // R4

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(io_wr && !io_sel_data &&
            (io_wdata == (alt_base ? KEY_FIN_HI : KEY_FIN_LO)))); // R2

    AST_EXIT_SEALS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_wr && io_sel_data && idx_cur == IDX_EXIT && io_wdata == EXIT_VAL)
        |=> !cfg_open); // R9

    AST_ID_HIGH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_rd && io_sel_data && idx_cur == IDX_ID_HI)
        |=> (io_rdata == CHIP_ID[15:8])); // R6

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_sel_data) |=> $stable(io_rdata)); // R5
endmodule

bind cfg_key_port cfgp_checker #(.CHIP_ID(CHIP_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_sel_data(io_sel_data), .io_wdata(io_wdata), .alt_base(alt_base),
    .io_rdata(io_rdata), .cfg_open(cfg_open), .idx_cur(idx_cur),
    .ctl_bits(seg_bits), .flash_base(flash_base)
);

// File: tb/test_cfg_key_port.sv
`timescale 1ns/1ps
module test_cfg_key_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_wr = 1'b0, io_rd = 1'b0, io_sel_data = 1'b0, alt_base = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic cfg_open, flash_suspend, flash_wr_en, flash_pin_sel;
    logic [2:0] seg_enable;
    logic [15:0] flash_base;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cfg_key_port i_cfg_key_port (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_sel_data(io_sel_data), .io_wdata(io_wdata), .alt_base(alt_base),
        .io_rdata(io_rdata), .cfg_open(cfg_open), .flash_suspend(flash_suspend),
        .seg_enable(seg_enable), .flash_wr_en(flash_wr_en),
        .flash_pin_sel(flash_pin_sel), .flash_base(flash_base)
    );

    // Behavioural reference model
    int        m_step;
    bit        m_open;
    bit [7:0]  m_idx, m_ldn, m_rd;
    bit [5:0]  m_ctl;
    bit [15:0] m_fb;

    function automatic bit [7:0] model_read(bit [7:0] ix);
        case (ix)
            8'h07: return m_ldn;
            8'h20: return 8'h87;
            8'h21: return 8'h16;
            8'h24: return {2'b00, m_ctl};
            8'h64: return (m_ldn == 8'h07) ? m_fb[15:8] : 8'h00;
            8'h65: return (m_ldn == 8'h07) ? m_fb[7:0]  : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = 0; m_open = 0; m_idx = 0; m_ldn = 0; m_rd = 8'hFF;
            m_ctl = 6'h00; m_fb = 16'h0290;
        end else begin
            bit was_open;
            bit [7:0] key [4];
            was_open = m_open;
            key[0] = 8'h87; key[1] = 8'h01; key[2] = 8'h55;
            key[3] = alt_base ? 8'hAA : 8'h55;
            if (io_rd && io_sel_data)
                m_rd = was_open ? model_read(m_idx) : 8'hFF;
            if (io_wr && !io_sel_data) begin
                if (was_open) m_idx = io_wdata;
                else if (io_wdata == key[m_step]) begin
                    m_step = m_step + 1;
                    if (m_step == 4) begin m_open = 1; m_step = 0; end
                end else m_step = (io_wdata == 8'h87) ? 1 : 0;
            end
            if (io_wr && io_sel_data && was_open) begin
                if (m_idx == 8'h02 && io_wdata == 8'h02) begin m_open = 0; m_step = 0; end
                else if (m_idx == 8'h07) m_ldn = io_wdata;
                else if (m_idx == 8'h24) m_ctl = io_wdata[5:0];
                else if (m_idx == 8'h64 && m_ldn == 8'h07) m_fb[15:8] = io_wdata;
                else if (m_idx == 8'h65 && m_ldn == 8'h07) m_fb[7:0]  = io_wdata;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Lock-step comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 cfg_open vs model", cfg_open, m_open);
            check("R5 io_rdata vs model", io_rdata, m_rd);
            check("R7 control outputs vs model",
                  {flash_pin_sel, flash_wr_en, seg_enable, flash_suspend}, m_ctl);
            check("R8 flash_base vs model", flash_base, m_fb);
        end
    end

    task automatic acc(bit wr, bit rd, bit sel, bit [7:0] b);
        @(negedge clk);
        io_wr = wr; io_rd = rd; io_sel_data = sel; io_wdata = b;
        @(negedge clk);
        io_wr = 0; io_rd = 0; io_sel_data = 0; io_wdata = 8'h00;
    endtask

    task automatic iwr(bit [7:0] b);  acc(1, 0, 0, b); endtask
    task automatic dwr(bit [7:0] b);  acc(1, 0, 1, b); endtask
    task automatic drd(string tag, bit [7:0] exp);
        acc(0, 1, 1, 8'h00);
        check(tag, io_rdata, exp);
    endtask
    task automatic reg_rd(string tag, bit [7:0] ix, bit [7:0] exp);
        iwr(ix); drd(tag, exp);
    endtask
    task automatic reg_wr(bit [7:0] ix, bit [7:0] v);
        iwr(ix); dwr(v);
    endtask
    task automatic key(bit [7:0] last);
        iwr(8'h87); iwr(8'h01); iwr(8'h55); iwr(last);
    endtask
    task automatic seal();
        reg_wr(8'h02, 8'h02);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 sealed after reset", cfg_open, 0);
        check("R1 rdata after reset", io_rdata, 8'hFF);
        check("R1 control outputs after reset",
              {flash_pin_sel, flash_wr_en, seg_enable, flash_suspend}, 0);
        check("R1 flash_base after reset", flash_base, 16'h0290);

        // R4 sealed: reads FF, writes inert
        drd("R4 sealed read", 8'hFF);
        dwr(8'h3F);
        check("R4 sealed write leaves outputs", {flash_pin_sel, flash_wr_en, seg_enable, flash_suspend}, 0);

        // R2 primary base key
        iwr(8'h87); iwr(8'h01); iwr(8'h55);
        check("R2 not open after three bytes", cfg_open, 0);
        iwr(8'h55);
        check("R2 open after primary key", cfg_open, 1);

        // R6 chip id
        reg_rd("R6 id high", 8'h20, 8'h87);
        reg_rd("R6 id low", 8'h21, 8'h16);
        reg_wr(8'h20, 8'h00);
        reg_rd("R6 id high after write", 8'h20, 8'h87);

        // R7 control register
        reg_wr(8'h24, 8'hFF);
        check("R7 all control outputs set", {flash_pin_sel, flash_wr_en, seg_enable, flash_suspend}, 6'h3F);
        drd("R7 readback masks bits 7:6", 8'h3F);
        reg_wr(8'h24, 8'h12);
        check("R7 bit4 drives flash_wr_en", flash_wr_en, 1);
        check("R7 bit1 drives seg_enable[0]", seg_enable, 3'b001);
        check("R7 suspend clear", flash_suspend, 0);

        // R8 logical-device banking
        reg_rd("R8 ldn reset", 8'h07, 8'h00);
        reg_rd("R8 base high hidden", 8'h64, 8'h00);
        dwr(8'h55);
        check("R8 hidden write ignored", flash_base, 16'h0290);
        reg_wr(8'h07, 8'h07);
        drd("R8 ldn readback", 8'h07);
        reg_rd("R8 base high visible", 8'h64, 8'h02);
        reg_rd("R8 base low visible", 8'h65, 8'h90);
        reg_wr(8'h64, 8'h0A);
        reg_wr(8'h65, 8'h30);
        check("R8 flash_base updated", flash_base, 16'h0A30);
        reg_wr(8'h07, 8'h03);
        reg_rd("R8 hidden again", 8'h65, 8'h00);

        // R10 unimplemented indices
        reg_wr(8'h30, 8'hA5);
        drd("R10 unimplemented reads zero", 8'h00);
        reg_rd("R10 low index reads zero", 8'h00, 8'h00);

        // R5 read hold and index-port read
        reg_rd("R5 read loads", 8'h24, 8'h12);
        acc(0, 1, 0, 8'h00);
        check("R5 index-port read leaves rdata", io_rdata, 8'h12);
        repeat (3) @(negedge clk);
        check("R5 rdata holds", io_rdata, 8'h12);

        // R9 exit register
        reg_wr(8'h02, 8'h01);
        check("R9 wrong exit value ignored", cfg_open, 1);
        dwr(8'h02);
        check("R9 sealed after exit", cfg_open, 0);
        drd("R9 read after exit", 8'hFF);
        dwr(8'h00);
        check("R4 sealed write to control ignored", flash_wr_en, 1);

        // R3 restart rules
        iwr(8'h87); iwr(8'h87); iwr(8'h01); iwr(8'h55); iwr(8'h55);
        check("R3 repeated 0x87 still opens", cfg_open, 1);
        seal();
        iwr(8'h87); iwr(8'h01); iwr(8'hAA); iwr(8'h55);
        check("R3 wrong third byte blocks", cfg_open, 0);
        iwr(8'h87); iwr(8'h01); iwr(8'h55); iwr(8'h87);
        iwr(8'h01); iwr(8'h55); iwr(8'h55);
        check("R3 0x87 restarts as first byte", cfg_open, 1);
        seal();
        iwr(8'h87); iwr(8'h01); drd("R3 data read mid-key", 8'hFF);
        iwr(8'h55); iwr(8'h55);
        check("R3 data access does not disturb match", cfg_open, 1);
        seal();

        // R2 alternate base
        alt_base = 1;
        key(8'h55);
        check("R2 primary final rejected on alt base", cfg_open, 0);
        key(8'hAA);
        check("R2 alt base key opens", cfg_open, 1);
        reg_rd("R2 access after alt open", 8'h21, 8'h16);
        seal();
        check("R9 sealed again", cfg_open, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule